// File: doc/BRIEF.md
# Early-Out Iterative Integer Divider

This block is the divide half of a multiply/divide unit. A single start strobe hands it a 32-bit dividend, a 32-bit divisor and a flag that selects signed or unsigned arithmetic. It returns the quotient into the LO register and the remainder into the HI register. It holds a busy flag for the whole operation and raises a one-cycle done pulse once the results are written. A core pipeline starts an operation and carries on. Any later attempt to read HI or LO while the divider is still working is held off by the stall output.

The latency depends on the data. A setup cycle takes the magnitudes of the operands and finds the highest nonzero byte of the dividend magnitude. Only that many bytes' worth of quotient bits are then produced, one bit per cycle, by restoring subtraction. Signed operations end with a correction cycle that negates the quotient when the operand signs differ and gives the remainder the sign of the dividend. When the `EARLY_OUT` parameter is 0, every operation iterates over the full word. In that mode each needed sign correction takes its own cycle.

Top module: `mdu_divider`

## Requirements
- R1: While rst_n is low, and in the first cycle after it rises, busy_o and done_o are 0, and hi_o and lo_o read 0.
- R2: For an unsigned operation with a nonzero divisor, lo_o takes the truncated quotient and hi_o takes the remainder. Both change in the same cycle in which done_o is 1.
- R3: For a signed operation (signed_i = 1, two's complement operands) with a nonzero divisor, lo_o is the quotient of the magnitudes. It is negated when exactly one operand is negative. hi_o is the remainder of the magnitudes, negated when the dividend is negative. Results wrap modulo 2^32.
- R4: In early-out mode, an unsigned operation keeps busy_o high for 9, 17, 25 or 33 cycles, starting in the cycle after the accepting clock edge. The count depends on which byte of the dividend is the highest nonzero one: byte 0 (this includes a zero dividend), byte 1, byte 2 or byte 3. done_o is high for exactly the one cycle after busy_o falls.
- R5: In early-out mode, a signed operation takes one cycle more than R4 gives. The byte class is taken from the magnitude of the dividend.
- R6: start_i is accepted only while busy_o is 0. A start_i pulse while busy_o is 1 is ignored: the running operation finishes with its own results and its own latency.
- R7: stall_o is 1 exactly when hilo_rd_i and busy_o are both 1.
- R8: A zero divisor does not hang the unit. The operation completes with the same latency as for a nonzero divisor, and the values written to HI and LO are unspecified.
- R9: hi_o and lo_o hold their values in every cycle in which done_o is 0.
- R10: With EARLY_OUT = 0, an unsigned operation takes 33 cycles. A signed operation takes 33 cycles plus one for a needed quotient negation (operand signs differ) and one for a needed remainder negation (dividend negative).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start strobe, sampled while idle |
| signed_i | input | 1 | 1 = signed two's complement divide |
| dividend_i | input | XLEN | Dividend |
| divisor_i | input | XLEN | Divisor |
| hilo_rd_i | input | 1 | Pipeline wants to read HI or LO |
| busy_o | output | 1 | Divide in progress |
| done_o | output | 1 | One-cycle pulse: HI/LO just written |
| stall_o | output | 1 | Hold off the HI/LO read |
| hi_o | output | XLEN | HI register (remainder) |
| lo_o | output | XLEN | LO register (quotient) |

## Verification
The assertions assume the operand and control inputs carry known values after reset, and that start_i is a plain level the block samples at the clock edge. hilo_rd_i is allowed to take any value in any cycle. The bench drives start_i and the operands on the falling edge and toggles hilo_rd_i at random just after the rising edge, so each input is stable around the edge that samples it. Its operand mix covers every dividend byte class, both signs of each operand, zero dividends and divisors, and the most negative dividend over minus one.

// File: rtl/mdu_div_pkg.sv
`timescale 1ns/1ps
// Package: shared state encoding for the divider controller.
// Assumes nothing beyond being compiled before its users.
package mdu_div_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_SETUP    = 3'd1,
        ST_ITER     = 3'd2,
        ST_FIX_BOTH = 3'd3,
        ST_FIX_QUO  = 3'd4,
        ST_FIX_REM  = 3'd5
    } div_state_e;

endpackage

// File: rtl/mdu_div_sizer.sv
`timescale 1ns/1ps
// Module: mdu_div_sizer
// Takes the magnitudes of the raw operands and works out the needed sign
// corrections. It also sizes the dividend: the number of iterations is
// SLICE times the index of its highest nonzero slice, plus one slice. The
// dividend magnitude comes out left-aligned, so its first significant slice
// sits at the top of the word. Purely combinational.
// Assumes XLEN is a whole multiple of SLICE.
module mdu_div_sizer #(
    parameter int XLEN      = 32,
    parameter int SLICE     = 8,
    parameter bit EARLY_OUT = 1'b1,
    localparam int NSLICE   = XLEN / SLICE,
    localparam int CNT_W    = $clog2(XLEN + 1)
) (
    input  logic             is_signed,
    input  logic [XLEN-1:0]  num,
    input  logic [XLEN-1:0]  den,
    output logic [XLEN-1:0]  num_aligned,
    output logic [XLEN-1:0]  den_mag,
    output logic [CNT_W-1:0] iters,
    output logic             neg_quo,
    output logic             neg_rem
);

    logic              num_neg;
    logic              den_neg;
    logic [XLEN-1:0]   num_mag;
    logic [NSLICE-1:0] slice_nz;

    // Operand signs and magnitudes.
    always_comb begin
        num_neg = is_signed & num[XLEN-1];
        den_neg = is_signed & den[XLEN-1];
        num_mag = num_neg ? (~num + XLEN'(1)) : num;
        den_mag = den_neg ? (~den + XLEN'(1)) : den;
        neg_quo = num_neg ^ den_neg;
        neg_rem = num_neg;
    end

    // Nonzero flag for every slice of the dividend magnitude.
    for (genvar g = 0; g < NSLICE; g++) begin : g_slice
        assign slice_nz[g] = |num_mag[g*SLICE +: SLICE];
    end

    if (EARLY_OUT) begin : g_early
        logic [CNT_W-1:0] used;
        logic [CNT_W-1:0] shamt;

        // Highest nonzero slice picks the iteration count.
        always_comb begin
            used = CNT_W'(1);
            for (int i = 1; i < NSLICE; i++) begin
                if (slice_nz[i]) used = CNT_W'(i + 1);
            end
            iters       = used * CNT_W'(SLICE);
            shamt       = CNT_W'(XLEN) - iters;
            num_aligned = num_mag << shamt;
        end
    end else begin : g_full
        // Full-width iteration: no alignment needed.
        always_comb begin
            iters       = CNT_W'(XLEN);
            num_aligned = num_mag;
        end
    end

endmodule

// File: rtl/mdu_div_step.sv
`timescale 1ns/1ps
// Module: mdu_div_step
// One restoring-division step. The next dividend bit is shifted into the
// partial remainder. The divisor is subtracted when it fits, and the
// resulting quotient bit enters the shift register from the bottom.
// Combinational.
// Assumes the incoming remainder is smaller than the divisor. For a zero
// divisor the step still produces a defined value, with no meaning.
module mdu_div_step #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] rem,
    input  logic [XLEN-1:0] quo,
    input  logic [XLEN-1:0] den,
    output logic [XLEN-1:0] rem_nx,
    output logic [XLEN-1:0] quo_nx
);

    logic [XLEN:0]   rem_sh;
    logic [XLEN+1:0] diff;
    logic            fits;

    // Trial subtraction with a guard bit that catches the borrow.
    always_comb begin
        rem_sh = {rem, quo[XLEN-1]};
        diff   = {1'b0, rem_sh} - {2'b00, den};
        fits   = ~diff[XLEN+1];
        rem_nx = fits ? diff[XLEN-1:0] : rem_sh[XLEN-1:0];
        quo_nx = {quo[XLEN-2:0], fits};
    end

endmodule

// File: rtl/mdu_div_fixup.sv
`timescale 1ns/1ps
// Module: mdu_div_fixup
// Two's complement negation of the quotient and/or the remainder, each
// under its own enable. Combinational.
// Assumes the enables are already qualified by the controller state.
module mdu_div_fixup #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] quo,
    input  logic [XLEN-1:0] rem,
    input  logic            flip_quo,
    input  logic            flip_rem,
    output logic [XLEN-1:0] quo_out,
    output logic [XLEN-1:0] rem_out
);

    // Conditional negation of each result word.
    always_comb begin
        quo_out = flip_quo ? (~quo + XLEN'(1)) : quo;
        rem_out = flip_rem ? (~rem + XLEN'(1)) : rem;
    end

endmodule

// File: rtl/mdu_divider.sv
`timescale 1ns/1ps
// Module: mdu_divider (top)
// Iterative divider of a multiply/divide unit. Operands are latched on an
// accepted start. A setup cycle sizes them, then one quotient bit is made
// per cycle. Signed results are corrected at the end, and the results are
// written into HI (remainder) and LO (quotient) with a one-cycle done pulse.
// busy_o covers the whole operation. stall_o holds off HI/LO reads while
// busy.
// Assumes a start while busy is to be ignored, and that divide-by-zero
// trapping is handled elsewhere.
module mdu_divider #(
    parameter int XLEN      = 32,
    parameter int SLICE     = 8,
    parameter bit EARLY_OUT = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic            signed_i,
    input  logic [XLEN-1:0] dividend_i,
    input  logic [XLEN-1:0] divisor_i,
    input  logic            hilo_rd_i,
    output logic            busy_o,
    output logic            done_o,
    output logic            stall_o,
    output logic [XLEN-1:0] hi_o,
    output logic [XLEN-1:0] lo_o
);
    import mdu_div_pkg::*;

    localparam int CNT_W = $clog2(XLEN + 1);

    div_state_e       state_q, state_d;
    logic             sgn_q, sgn_d;
    logic [XLEN-1:0]  num_q, num_d;
    logic [XLEN-1:0]  den_q, den_d;
    logic [XLEN-1:0]  dmag_q, dmag_d;
    logic [XLEN-1:0]  rem_q, rem_d;
    logic [XLEN-1:0]  quo_q, quo_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             nq_q, nq_d;
    logic             nr_q, nr_d;
    logic [XLEN-1:0]  hi_q, lo_q;
    logic             done_q;

    logic             fin;
    logic [XLEN-1:0]  res_hi, res_lo;

    logic [XLEN-1:0]  sz_num, sz_den;
    logic [CNT_W-1:0] sz_iters;
    logic             sz_nq, sz_nr;
    logic [XLEN-1:0]  st_rem, st_quo;
    logic             fx_q_en, fx_r_en;
    logic [XLEN-1:0]  fx_quo, fx_rem;

    mdu_div_sizer #(
        .XLEN      (XLEN),
        .SLICE     (SLICE),
        .EARLY_OUT (EARLY_OUT)
    ) u_sizer (
        .is_signed   (sgn_q),
        .num         (num_q),
        .den         (den_q),
        .num_aligned (sz_num),
        .den_mag     (sz_den),
        .iters       (sz_iters),
        .neg_quo     (sz_nq),
        .neg_rem     (sz_nr)
    );

    mdu_div_step #(.XLEN(XLEN)) u_step (
        .rem    (rem_q),
        .quo    (quo_q),
        .den    (dmag_q),
        .rem_nx (st_rem),
        .quo_nx (st_quo)
    );

    // Correction enables follow the correction state in progress.
    always_comb begin
        fx_q_en = nq_q & ((state_q == ST_FIX_BOTH) | (state_q == ST_FIX_QUO));
        fx_r_en = nr_q & ((state_q == ST_FIX_BOTH) | (state_q == ST_FIX_REM));
    end

    mdu_div_fixup #(.XLEN(XLEN)) u_fix (
        .quo      (quo_q),
        .rem      (rem_q),
        .flip_quo (fx_q_en),
        .flip_rem (fx_r_en),
        .quo_out  (fx_quo),
        .rem_out  (fx_rem)
    );

    // Controller: sequencing, datapath loads and the final write strobe.
    always_comb begin
        state_d = state_q;
        sgn_d   = sgn_q;
        num_d   = num_q;
        den_d   = den_q;
        dmag_d  = dmag_q;
        rem_d   = rem_q;
        quo_d   = quo_q;
        cnt_d   = cnt_q;
        nq_d    = nq_q;
        nr_d    = nr_q;
        fin     = 1'b0;
        res_hi  = rem_q;
        res_lo  = quo_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    num_d   = dividend_i;
                    den_d   = divisor_i;
                    sgn_d   = signed_i;
                    state_d = ST_SETUP;
                end
            end
            ST_SETUP: begin
                rem_d   = '0;
                quo_d   = sz_num;
                dmag_d  = sz_den;
                cnt_d   = sz_iters;
                nq_d    = sz_nq;
                nr_d    = sz_nr;
                state_d = ST_ITER;
            end
            ST_ITER: begin
                rem_d = st_rem;
                quo_d = st_quo;
                cnt_d = cnt_q - CNT_W'(1);
                if (cnt_q == CNT_W'(1)) begin
                    if (!sgn_q || (!EARLY_OUT && !nq_q && !nr_q)) begin
                        fin     = 1'b1;
                        res_hi  = st_rem;
                        res_lo  = st_quo;
                        state_d = ST_IDLE;
                    end else if (EARLY_OUT) begin
                        state_d = ST_FIX_BOTH;
                    end else if (nq_q) begin
                        state_d = ST_FIX_QUO;
                    end else begin
                        state_d = ST_FIX_REM;
                    end
                end
            end
            ST_FIX_BOTH: begin
                fin     = 1'b1;
                res_hi  = fx_rem;
                res_lo  = fx_quo;
                state_d = ST_IDLE;
            end
            ST_FIX_QUO: begin
                quo_d = fx_quo;
                if (nr_q) begin
                    state_d = ST_FIX_REM;
                end else begin
                    fin     = 1'b1;
                    res_hi  = rem_q;
                    res_lo  = fx_quo;
                    state_d = ST_IDLE;
                end
            end
            ST_FIX_REM: begin
                fin     = 1'b1;
                res_hi  = fx_rem;
                res_lo  = quo_q;
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Controller and datapath registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            sgn_q   <= 1'b0;
            num_q   <= '0;
            den_q   <= '0;
            dmag_q  <= '0;
            rem_q   <= '0;
            quo_q   <= '0;
            cnt_q   <= '0;
            nq_q    <= 1'b0;
            nr_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            sgn_q   <= sgn_d;
            num_q   <= num_d;
            den_q   <= den_d;
            dmag_q  <= dmag_d;
            rem_q   <= rem_d;
            quo_q   <= quo_d;
            cnt_q   <= cnt_d;
            nq_q    <= nq_d;
            nr_q    <= nr_d;
        end
    end

    // HI/LO architectural registers and the done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q   <= '0;
            lo_q   <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= fin;
            if (fin) begin
                hi_q <= res_hi;
                lo_q <= res_lo;
            end
        end
    end

    // Status and read interlock.
    always_comb begin
        busy_o  = (state_q != ST_IDLE);
        stall_o = hilo_rd_i & busy_o;
        done_o  = done_q;
        hi_o    = hi_q;
        lo_o    = lo_q;
    end

endmodule

// File: rtl/mdu_divider_chk.sv
`timescale 1ns/1ps
// Module: mdu_divider_chk
// Protocol and timing properties of the divider, watched at its ports.
// Assumes a synchronous active-low reset that is applied from time zero.
module mdu_divider_chk #(
    parameter int XLEN  = 32,
    parameter int SLICE = 8,
    localparam int MIN_LAT = SLICE + 1,
    localparam int MAX_LAT = XLEN + 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start_i,
    input logic            hilo_rd_i,
    input logic            busy_o,
    input logic            done_o,
    input logic            stall_o,
    input logic [XLEN-1:0] hi_o,
    input logic [XLEN-1:0] lo_o
);

    logic [7:0] run_len;

    // Counts the cycles of the current busy run.
    always_ff @(posedge clk) begin
        if (!rst_n)      run_len <= '0;
        else if (busy_o) run_len <= run_len + 8'd1;
        else             run_len <= '0;
    end

    p_done_after_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o)));

    p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_latency_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> (run_len >= 8'(MIN_LAT) && run_len <= 8'(MAX_LAT)));

    p_start_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);

    p_stall_only_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        stall_o |-> (busy_o && hilo_rd_i));

    p_hilo_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(hi_o) && $stable(lo_o)));

endmodule

bind mdu_divider mdu_divider_chk #(.XLEN(XLEN), .SLICE(SLICE)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .hilo_rd_i (hilo_rd_i),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .stall_o   (stall_o),
    .hi_o      (hi_o),
    .lo_o      (lo_o)
);

// File: tb/tb_mdu_divider.sv
`timescale 1ns/1ps
// Bench: drives the early-out divider (dut) and a full-width one (dut_slow)
// with the same stimulus, and compares both against a behavioural model on
// every clock.
module tb_mdu_divider;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        sgn = 1'b0;
    logic [31:0] opa = '0;
    logic [31:0] opb = '0;
    logic        rd = 1'b0;

    logic        busy  [2];
    logic        done  [2];
    logic        stall [2];
    logic [31:0] hi    [2];
    logic [31:0] lo    [2];

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit ended = 1'b0;
    bit ticked = 1'b0;

    always #2 clk = ~clk;

    mdu_divider #(.XLEN(32), .SLICE(8), .EARLY_OUT(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .signed_i(sgn),
        .dividend_i(opa), .divisor_i(opb), .hilo_rd_i(rd),
        .busy_o(busy[0]), .done_o(done[0]), .stall_o(stall[0]),
        .hi_o(hi[0]), .lo_o(lo[0]));

    mdu_divider #(.XLEN(32), .SLICE(8), .EARLY_OUT(1'b0)) dut_slow (
        .clk(clk), .rst_n(rst_n), .start_i(start), .signed_i(sgn),
        .dividend_i(opa), .divisor_i(opb), .hilo_rd_i(rd),
        .busy_o(busy[1]), .done_o(done[1]), .stall_o(stall[1]),
        .hi_o(hi[1]), .lo_o(lo[1]));

    // Reference model state, one slot per instance.
    bit          m_busy [2];
    bit          m_done [2];
    int          m_cnt  [2];
    logic [31:0] m_hi   [2];
    logic [31:0] m_lo   [2];
    bit          m_known[2];
    bit          m_sgn  [2];
    bit          m_zero [2];
    logic [31:0] p_hi   [2];
    logic [31:0] p_lo   [2];
    bit          p_known[2];

    function automatic logic [31:0] mag(logic [31:0] v, bit s);
        return (s && v[31]) ? (32'd0 - v) : v;
    endfunction

    // Latency from the requirements: R4/R5 early-out, R10 full width.
    function automatic int lat_of(int k, logic [31:0] a, logic [31:0] b, bit s);
        logic [31:0] ma = mag(a, s);
        bit na = s && a[31];
        bit nb = s && b[31];
        int nbytes = (ma[31:24] != 0) ? 4 : (ma[23:16] != 0) ? 3 :
                     (ma[15:8] != 0) ? 2 : 1;
        if (k == 0) return 8 * nbytes + 1 + (s ? 1 : 0);
        return 33 + (s ? (int'(na != nb) + int'(na)) : 0);
    endfunction

    // Model update on every rising edge.
    always @(posedge clk) begin
        for (int k = 0; k < 2; k++) begin
            if (!rst_n) begin
                m_busy[k] = 0; m_done[k] = 0; m_cnt[k] = 0;
                m_hi[k] = '0; m_lo[k] = '0; m_known[k] = 1;
                m_sgn[k] = 0; m_zero[k] = 0;
            end else begin
                m_done[k] = 0;
                if (m_busy[k]) begin
                    m_cnt[k]--;
                    if (m_cnt[k] == 0) begin
                        m_busy[k] = 0; m_done[k] = 1;
                        m_hi[k] = p_hi[k]; m_lo[k] = p_lo[k];
                        m_known[k] = p_known[k];
                    end
                end else if (start) begin
                    logic [31:0] ma, mb, q, r;
                    ma = mag(opa, sgn);
                    mb = mag(opb, sgn);
                    m_busy[k] = 1;
                    m_cnt[k]  = lat_of(k, opa, opb, sgn);
                    m_sgn[k]  = sgn;
                    m_zero[k] = (opb == 0);
                    p_known[k] = (opb != 0);
                    q = (mb == 0) ? '0 : ma / mb;
                    r = (mb == 0) ? '0 : ma % mb;
                    if (sgn && (opa[31] != opb[31])) q = 32'd0 - q;
                    if (sgn && opa[31]) r = 32'd0 - r;
                    p_hi[k] = r; p_lo[k] = q;
                end
            end
        end
        ticked = 1'b1;
    end

    task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // Per-cycle comparison, away from the rising edge.
    always @(negedge clk) begin
        if (ticked && !ended) begin
            for (int k = 0; k < 2; k++) begin
                string tl, tv;
                if (!rst_n)         tl = "R1";
                else if (k == 1)    tl = "R10";
                else if (m_zero[k]) tl = "R8";
                else if (m_sgn[k])  tl = "R5";
                else                tl = "R4";
                check(busy[k] === m_busy[k], tl, 32'(busy[k]), 32'(m_busy[k]));
                check(done[k] === m_done[k], tl, 32'(done[k]), 32'(m_done[k]));
                check(stall[k] === (rd && m_busy[k]), "R7", 32'(stall[k]),
                      32'(rd && m_busy[k]));
                if (m_known[k]) begin
                    if (!rst_n)        tv = "R1";
                    else if (!m_done[k]) tv = "R9";
                    else if (m_sgn[k]) tv = "R3";
                    else               tv = "R2";
                    check(hi[k] === m_hi[k], tv, hi[k], m_hi[k]);
                    check(lo[k] === m_lo[k], tv, lo[k], m_lo[k]);
                end
            end
        end
    end

    // Random read requests, changed just after the rising edge.
    always @(posedge clk) rd <= 1'($urandom % 2);

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    // Watchdog: a hung run is a failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !ended) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog act=%0d exp=<150000", cyc);
            finish_run();
        end
    end

    task automatic wait_idle();
        while (m_busy[0] || m_busy[1]) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic run_op(logic [31:0] a, logic [31:0] b, bit s);
        @(negedge clk);
        opa = a; opb = b; sgn = s; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_idle();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: outputs after reset (also compared by the model each cycle).
        check(busy[0] === 1'b0 && done[0] === 1'b0, "R1", 32'(busy[0]), 32'd0);
        check(hi[0] === 32'd0 && lo[0] === 32'd0, "R1", hi[0] | lo[0], 32'd0);
        // R2 / R4: every dividend byte class, unsigned.
        run_op(32'h0000_005A, 32'd7, 1'b0);
        run_op(32'h0000_1234, 32'd3, 1'b0);
        run_op(32'h00AB_CDEF, 32'h0000_0100, 1'b0);
        run_op(32'hFFFF_FFFF, 32'h0000_0010, 1'b0);
        run_op(32'h0000_0000, 32'd5, 1'b0);
        run_op(32'h0000_0003, 32'hFFFF_FFFF, 1'b0);
        // R3 / R5 / R10: sign combinations and the most negative dividend.
        run_op(-32'sd100, 32'd7, 1'b1);
        run_op(32'd100, -32'sd7, 1'b1);
        run_op(-32'sd100, -32'sd7, 1'b1);
        run_op(32'h8000_0000, 32'hFFFF_FFFF, 1'b1);
        run_op(32'hFFFF_FFFF, 32'd2, 1'b1);
        run_op(-32'sd70000, 32'd300, 1'b1);
        // R8: zero divisor completes.
        run_op(32'd1234, 32'd0, 1'b0);
        run_op(-32'sd5, 32'd0, 1'b1);
        // R6: a second start while busy is ignored.
        @(negedge clk);
        opa = 32'h0001_0000; opb = 32'd16; sgn = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        opa = 32'd9; opb = 32'd2; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_idle();
        check(lo[0] === 32'h0000_1000, "R6", lo[0], 32'h0000_1000);
        check(hi[0] === 32'd0, "R6", hi[0], 32'd0);
        // Mixed random operands across byte classes and signs.
        for (int i = 0; i < 120; i++) begin
            logic [31:0] a, b;
            a = $urandom >> (8 * ($urandom % 4));
            b = $urandom >> ($urandom % 32);
            if (i % 17 == 0) b = 32'd0;
            run_op(a, b, 1'($urandom % 2));
        end
        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule